// File: doc/BRIEF.md
# Resonant Rectifier Gate Timing Estimator

This block times the gate of one synchronous rectifier switch on the secondary side of a resonant converter. Its input is a digitized comparator that reads high while the switch's drain-source voltage is above a small threshold and low while current flows. The block counts how long each low phase lasts. When a low phase has persisted through a debounce delay, it turns the gate on. It then turns the gate off early, after a predicted interval: the previous low phase minus a programmed dead time.

The predicted interval can be cut back by three independent shrink sources, and their reductions add. The first is a dead-time miss seen after the previous turn-off. The second is comparator ringing near zero. The third is a flag raised by outside feedback-rate logic. The interval is also bounded by a growth cap relative to the previous on-time and by an absolute maximum. A minimum on-time keeps a premature comparator edge from ending the pulse. After each turn-off, a re-trigger inhibit runs with a length chosen by a frequency-range input. An enable input from green-mode and protection logic gates the output directly.

All timing constants are parameters counted in clock cycles. The dead time arrives as a cycle count on a port.

Top module: `sr_gate_timer`

## Requirements
- R1: The gate rises in the cycle after the DEB-th consecutive low sample of `det_i`. A low phase shorter than DEB samples neither turns the gate on nor changes the stored measurement.
- R2: Each low phase of at least DEB samples is stored as the measurement. A pulse started while the next low phase is in progress lasts `meas - dead_cycles_i` cycles, as long as no other rule cuts it.
- R3: Suppose `det_i` is sampled high in any of the first DW cycles after a turn-off. The next pulse that fires is then shortened by a further SHR_DT cycles.
- R4: A low phase shorter than RING_WIN samples, followed by more than RING_HIGH consecutive high samples, marks ringing. The next pulse that fires is then shortened by SHR_RNG cycles.
- R5: When `fb_shrink_i` is high at the firing instant, the pulse is shortened by SHR_FD cycles. All active shrink amounts and the dead time add.
- R6: A computed on-time below one cycle yields no pulse. After reset the measurement is zero, so the first low phase produces no pulse.
- R7: `det_i` high ends a pulse only once it has lasted MIN_ON cycles. A pulse whose target is reached earlier still ends at its target.
- R8: No pulse lasts longer than MAX_ON cycles.
- R9: After a turn-off, no new pulse can fire until INH_LF cycles have passed when `hf_mode_i` is 0, or INH_HF cycles when it is 1. A low phase whose debounce completes inside that window produces no pulse.
- R10: If the previous pulse lasted P cycles with P at least MIN_ON, the new pulse is at most P + floor(P*GROW_Q8/256) cycles.
- R11: While `gate_en_i` is low, `gate_o` is low in the same cycle, and a firing instant starts no pulse. The firing instant still consumes the pending shrink flags.
- R12: While `rst_ni` is low, `gate_o` is low and all measurements, flags and the previous on-time are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| det_i | input | 1 | Digitized comparator, 1 = drain voltage above threshold |
| gate_en_i | input | 1 | Gate enable from green-mode and protection logic |
| fb_shrink_i | input | 1 | Feedback-rise shrink request |
| hf_mode_i | input | 1 | 1 selects the high-frequency inhibit length |
| dead_cycles_i | input | CNT_W | Programmed dead time in cycles |
| gate_o | output | 1 | Rectifier gate command |

## Verification
The hardest states to reach are the ones that depend on several past cycles at once. The growth cap only shows once the previous pulse is short while the stored measurement is long. A stacked shrink needs a ringing mark, the feedback flag and a dead-time miss pending at one firing instant. The stimulus reaches these states with chained switching periods. A long low phase after a short one walks the cap up step by step. A sub-debounce low pulse followed by a long high phase arms the ringing mark without firing a pulse. A low phase that ends just after a short pulse triggers the dead-time miss. The inhibit is reached by shortening the high phase after a predicted turn-off, so that the next debounce completes inside or just outside the window for each mode.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;
  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_ON   = 2'd1,
    GS_INH  = 2'd2
  } gate_state_e;
endpackage

// File: rtl/sr_det_monitor.sv
module sr_det_monitor #(
  parameter int CNT_W     = 12,
  parameter int DEB       = 15,
  parameter int RING_WIN  = 35,
  parameter int RING_HIGH = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             det_i,
  input  logic             ring_clr_i,
  output logic [CNT_W-1:0] low_cnt_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             ring_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] DEB_C    = CNT_W'(DEB);
  localparam logic [CNT_W-1:0] RWIN_C   = CNT_W'(RING_WIN);
  localparam logic [CNT_W-1:0] RHIGH_C  = CNT_W'(RING_HIGH);

  logic [CNT_W-1:0] hi_cnt;
  logic             arm_q;
  logic             rise;
  logic             ring_hit;

  // previous sample was low iff the low run is nonzero
  assign rise     = det_i && (low_cnt_o != '0);
  assign ring_hit = arm_q && det_i && (hi_cnt == RHIGH_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_o <= '0;
      hi_cnt    <= '0;
      meas_o    <= '0;
      arm_q     <= 1'b0;
      ring_o    <= 1'b0;
    end else begin
      if (det_i) low_cnt_o <= '0;
      else if (low_cnt_o != CNT_MAX) low_cnt_o <= low_cnt_o + 1'b1;

      if (!det_i) hi_cnt <= '0;
      else if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;

      if (rise && low_cnt_o >= DEB_C) meas_o <= low_cnt_o;

      if (!det_i) arm_q <= 1'b0;
      else if (rise) arm_q <= (low_cnt_o < RWIN_C);
      else if (ring_hit) arm_q <= 1'b0;

      if (ring_hit) ring_o <= 1'b1;
      else if (ring_clr_i) ring_o <= 1'b0;
    end
  end

  assert_ring_needs_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ring_o) |-> $past(det_i) && $past(hi_cnt) == RHIGH_C);

  assert_short_low_keeps_meas_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_i && low_cnt_o != '0 && low_cnt_o < DEB_C) |=> $stable(meas_o));
endmodule

// File: rtl/sr_target_calc.sv
module sr_target_calc #(
  parameter int CNT_W   = 12,
  parameter int MIN_ON  = 30,
  parameter int MAX_ON  = 1050,
  parameter int SHR_DT  = 125,
  parameter int SHR_RNG = 120,
  parameter int SHR_FD  = 140,
  parameter int GROW_Q8 = 102
) (
  input  logic [CNT_W-1:0] meas_i,
  input  logic [CNT_W-1:0] prev_on_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic             dt_i,
  input  logic             ring_i,
  input  logic             fb_i,
  output logic [CNT_W-1:0] target_o
);
  localparam int SW = CNT_W + 3;
  localparam int PW = CNT_W + 9;

  logic [SW-1:0] shrink, base, grow_lim, capped;
  logic [PW-1:0] prod;

  assign shrink = SW'(dead_i)
                + (dt_i   ? SW'(SHR_DT)  : SW'(0))
                + (ring_i ? SW'(SHR_RNG) : SW'(0))
                + (fb_i   ? SW'(SHR_FD)  : SW'(0));
  assign base     = (SW'(meas_i) > shrink) ? SW'(meas_i) - shrink : '0;
  assign prod     = PW'(prev_on_i) * PW'(GROW_Q8);
  assign grow_lim = SW'(prev_on_i) + SW'(prod >> 8);
  assign capped   = (prev_on_i >= CNT_W'(MIN_ON) && base > grow_lim) ? grow_lim : base;
  assign target_o = (capped > SW'(MAX_ON)) ? CNT_W'(MAX_ON) : capped[CNT_W-1:0];
endmodule

// File: rtl/sr_gate_fsm.sv
module sr_gate_fsm import sr_gate_pkg::*; #(
  parameter int CNT_W  = 12,
  parameter int DEB    = 15,
  parameter int MIN_ON = 30,
  parameter int MAX_ON = 1050,
  parameter int INH_LF = 210,
  parameter int INH_HF = 145,
  parameter int DW     = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             det_i,
  input  logic             en_i,
  input  logic             hf_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             gate_q_o,
  output logic             fire_o,
  output logic             dt_short_o,
  output logic [CNT_W-1:0] prev_on_o
);
  localparam logic [CNT_W-1:0] FIRE_AT  = CNT_W'(DEB - 1);
  localparam logic [CNT_W-1:0] MIN_ON_C = CNT_W'(MIN_ON);
  localparam logic [CNT_W-1:0] MAX_ON_C = CNT_W'(MAX_ON);
  localparam logic [CNT_W-1:0] DW_C     = CNT_W'(DW);
  localparam logic [CNT_W-1:0] INH_MIN  = CNT_W'((INH_LF < INH_HF) ? INH_LF : INH_HF);

  gate_state_e      state;
  logic [CNT_W-1:0] on_cnt, inh_cnt, tgt_q, inh_len, off_gap;
  logic             stop_on;

  assign inh_len  = hf_i ? CNT_W'(INH_HF) : CNT_W'(INH_LF);
  assign fire_o   = (state == GS_IDLE) && !det_i && (low_cnt_i == FIRE_AT);
  assign stop_on  = !en_i || (on_cnt >= tgt_q) || (det_i && on_cnt >= MIN_ON_C)
                 || (on_cnt >= MAX_ON_C);
  assign gate_q_o = (state == GS_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= GS_IDLE;
      on_cnt     <= '0;
      inh_cnt    <= '0;
      tgt_q      <= '0;
      dt_short_o <= 1'b0;
      prev_on_o  <= '0;
    end else begin
      case (state)
        GS_IDLE: if (fire_o) begin
          dt_short_o <= 1'b0;
          if (en_i && target_i != '0) begin
            state  <= GS_ON;
            on_cnt <= CNT_W'(1);
            tgt_q  <= target_i;
          end
        end
        GS_ON: if (stop_on) begin
          state     <= GS_INH;
          inh_cnt   <= CNT_W'(1);
          prev_on_o <= on_cnt;
        end else begin
          on_cnt <= on_cnt + 1'b1;
        end
        GS_INH: begin
          if (det_i && inh_cnt <= DW_C) dt_short_o <= 1'b1;
          if (inh_cnt >= inh_len) state <= GS_IDLE;
          else inh_cnt <= inh_cnt + 1'b1;
        end
        default: state <= GS_IDLE;
      endcase
    end
  end

  // checker: cycles since the gate last fell
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_gap <= '1;
    else if (gate_q_o) off_gap <= '0;
    else if (off_gap != '1) off_gap <= off_gap + 1'b1;
  end

  assert_debounce_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q_o) |-> !$past(det_i) && $past(low_cnt_i) == FIRE_AT);

  assert_min_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_q_o) && $past(en_i)) |-> ($past(on_cnt) >= MIN_ON_C || $past(on_cnt) >= $past(tgt_q)));

  assert_max_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q_o |-> on_cnt <= MAX_ON_C);

  assert_inhibit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q_o) |-> off_gap >= INH_MIN);

  assert_enable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_q_o);
endmodule

// File: rtl/sr_gate_timer.sv
module sr_gate_timer #(
  parameter int CNT_W     = 12,
  parameter int DEB       = 15,
  parameter int MIN_ON    = 30,
  parameter int MAX_ON    = 1050,
  parameter int INH_LF    = 210,
  parameter int INH_HF    = 145,
  parameter int DW        = 13,
  parameter int RING_WIN  = 35,
  parameter int RING_HIGH = 15,
  parameter int SHR_DT    = 125,
  parameter int SHR_RNG   = 120,
  parameter int SHR_FD    = 140,
  parameter int GROW_Q8   = 102
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             det_i,
  input  logic             gate_en_i,
  input  logic             fb_shrink_i,
  input  logic             hf_mode_i,
  input  logic [CNT_W-1:0] dead_cycles_i,
  output logic             gate_o
);
  logic [CNT_W-1:0] low_cnt, meas, prev_on, target;
  logic             ring, fire, dt_short, gate_q;

  sr_det_monitor #(
    .CNT_W(CNT_W), .DEB(DEB), .RING_WIN(RING_WIN), .RING_HIGH(RING_HIGH)
  ) u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .det_i(det_i), .ring_clr_i(fire),
    .low_cnt_o(low_cnt), .meas_o(meas), .ring_o(ring)
  );

  sr_target_calc #(
    .CNT_W(CNT_W), .MIN_ON(MIN_ON), .MAX_ON(MAX_ON), .SHR_DT(SHR_DT),
    .SHR_RNG(SHR_RNG), .SHR_FD(SHR_FD), .GROW_Q8(GROW_Q8)
  ) u_calc (
    .meas_i(meas), .prev_on_i(prev_on), .dead_i(dead_cycles_i),
    .dt_i(dt_short), .ring_i(ring), .fb_i(fb_shrink_i), .target_o(target)
  );

  sr_gate_fsm #(
    .CNT_W(CNT_W), .DEB(DEB), .MIN_ON(MIN_ON), .MAX_ON(MAX_ON),
    .INH_LF(INH_LF), .INH_HF(INH_HF), .DW(DW)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .det_i(det_i), .en_i(gate_en_i),
    .hf_i(hf_mode_i), .low_cnt_i(low_cnt), .target_i(target),
    .gate_q_o(gate_q), .fire_o(fire), .dt_short_o(dt_short), .prev_on_o(prev_on)
  );

  assign gate_o = gate_q & gate_en_i;

  assert_reset_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !gate_o);
endmodule

// File: tb/sr_gate_timer_tb.sv
module sr_gate_timer_tb;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic det = 1'b1;
  logic gate_en = 1'b1;
  logic fb = 1'b0;
  logic hf = 1'b0;
  logic [CNT_W-1:0] dead = CNT_W'(8);
  logic gate;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sr_gate_timer #(
    .CNT_W(CNT_W), .DEB(3), .MIN_ON(4), .MAX_ON(80), .INH_LF(20), .INH_HF(12),
    .DW(3), .RING_WIN(6), .RING_HIGH(3), .SHR_DT(10), .SHR_RNG(8), .SHR_FD(12),
    .GROW_Q8(102)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .det_i(det), .gate_en_i(gate_en),
    .fb_shrink_i(fb), .hf_mode_i(hf), .dead_cycles_i(dead), .gate_o(gate)
  );

  // {low samples, high samples, feedback flag, expected pulse width}
  // dead = 8, shrinks dt/ring/fb = 10/8/12, min on 4, max on 80, cap 102/256
  localparam int NV = 21;
  localparam int VEC [NV][4] = '{
    '{ 40, 40, 0,  0},  // R6 first phase after reset
    '{ 40, 40, 0, 32},  // R2 40-8
    '{100, 40, 0, 32},  // R2 uses previous measurement
    '{100, 40, 0, 44},  // R10 32+12
    '{100, 40, 0, 61},  // R10 44+17
    '{100, 40, 0, 80},  // R8 max on
    '{ 60, 40, 0, 58},  // R7 ended by input high
    '{ 60, 40, 0, 42},  // R3 60-8-10
    '{ 60, 40, 1, 40},  // R5 60-8-12
    '{ 60, 40, 0, 52},  // R2
    '{  2, 40, 0,  0},  // R1 short low ignored, R4 arms ringing
    '{ 60, 40, 0, 44},  // R4 60-8-8
    '{  2, 40, 0,  0},  // R4 arm again
    '{ 60, 40, 1, 32},  // R5 additive ring+fb
    '{ 10, 40, 0,  8},  // R7 input high ends pulse
    '{ 10, 40, 0,  0},  // R6 clamp to zero
    '{  4, 40, 0,  2},  // R7 target below min on wins
    '{ 60, 40, 0,  0},  // R6 clamp
    '{ 60, 40, 0, 52},  // R10 no cap below min on
    '{  4, 40, 0,  4},  // R7 min on hold
    '{ 60, 40, 0,  0}   // R6 clamp
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cycle(input int lo, input int hi, input logic fbv,
                           input logic env, output int w);
    w = 0;
    fb = fbv;
    gate_en = env;
    for (int i = 0; i < lo + hi; i++) begin
      @(negedge clk);
      if (gate) w++;
      det = (i >= lo);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    det = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    check("R12 gate low in reset", int'(gate), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R12 gate low after reset", int'(gate), 0);

    for (int v = 0; v < NV; v++) begin
      run_cycle(VEC[v][0], VEC[v][1], VEC[v][2][0], 1'b1, w);
      check($sformatf("R2/R3/R4/R5/R6/R7/R8/R10 vector %0d", v), w, VEC[v][3]);
    end

    // R11 enable low: no pulse, flags consumed
    run_cycle(60, 40, 1'b0, 1'b0, w);
    check("R11 disabled pulse", w, 0);
    run_cycle(60, 40, 1'b0, 1'b1, w);
    check("R10 cap from prev 4", w, 5);

    // R11 enable drop mid pulse
    gate_en = 1'b1;
    fb = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (i == 5) begin
        check("R11 gate high before drop", int'(gate), 1);
        gate_en = 1'b0;
        #1;
        check("R11 gate low same cycle", int'(gate), 0);
      end
      det = (i >= 60);
    end
    gate_en = 1'b1;

    // R9 inhibit, low-frequency length
    do_reset();
    hf = 1'b0;
    run_cycle(60, 40, 1'b0, 1'b1, w);
    check("R6 first after reset", w, 0);
    run_cycle(60, 40, 1'b0, 1'b1, w);
    check("R2 base pulse", w, 52);
    run_cycle(60, 10, 1'b0, 1'b1, w);
    check("R9 pulse before short high", w, 52);
    run_cycle(60, 40, 1'b0, 1'b1, w);
    check("R9 LF inhibit blocks", w, 0);

    // R9 inhibit, high-frequency length
    hf = 1'b1;
    run_cycle(60, 10, 1'b0, 1'b1, w);
    check("R9 HF pulse", w, 52);
    run_cycle(60, 4, 1'b0, 1'b1, w);
    check("R9 HF inhibit allows", w, 52);
    run_cycle(60, 40, 1'b0, 1'b1, w);
    check("R9 HF inhibit blocks", w, 0);
    hf = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule